// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a bank of general-purpose pins behind a small 32-bit register interface. Software picks, per pin, whether the pin is driven by the controller's own registers or handed to an alternate-function path. Under register control each pin can be an input or an output, with its own output enable and output level. The pin levels pass through a synchronizer and can be read back at any time.

Each pin can raise an interrupt. A pin can detect a level (high or low) or an edge (rising, falling or both). Detected events are latched in a status register. Reading that register returns the latched bits and clears them. A per-pin mask, changed only through separate set and clear strobe registers, decides which latched bits reach the single combined interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (direction reads all ones on implemented bits). The bypass, output enable, output value, interrupt type, interrupt value, any-edge and status registers read zero. Every interrupt is masked, so the mask reads all ones, and `irq` is low.
- R2: The registers sit at these byte offsets: 0x00 bypass, 0x04 direction, 0x08 output enable, 0x0C output value, 0x10 input value, 0x14 mask, 0x18 unmask strobe, 0x1C mask strobe, 0x20 status, 0x24 type, 0x28 polarity, 0x2C any-edge. Bit n belongs to pin n. Bits at or above NPINS read as zero.
- R3: A pin with bypass 0 and direction 0 is an output. It drives `pin_oe` from its output enable bit and `pin_out` from its output value bit. A pin with direction 1 is an input, and `pin_oe` stays 0 whatever its output enable bit holds.
- R4: A pin with bypass 1 takes `pin_out` from `alt_out` and `pin_oe` from `alt_oe`. `alt_in` always presents the raw pin levels.
- R5: Writing 1 to a bit at 0x18 clears that mask bit, and writing 1 at 0x1C sets it. Bits written 0 leave the mask unchanged. A write to 0x14 has no effect, and the strobe offsets read as zero.
- R6: A type bit of 1 selects level detection. Polarity 1 means active high and polarity 0 means active low. The status bit is set on every cycle the synchronized level is active.
- R7: A type bit of 0 selects edge detection. With any-edge 1, both edges set status. With any-edge 0, polarity 1 means rising and polarity 0 means falling. A transition in the other direction is ignored.
- R8: A read of 0x20 returns the latched status and clears it. An event present at the clock edge of that read stays latched, and a level that is still active shows up again in the next read.
- R9: Status bits latch whether or not the pin is masked. `irq` is high exactly when some status bit with a clear mask bit is set.
- R10: Pins pass through two flops before the input value register and the detectors. A read issued in the same cycle the pin changes, or in the cycle after, returns the old level, and the read after that returns the new level.
- R11: Read data appears on `bus_rdata` one cycle after the read request and holds until the next read. Writes take effect at the clock edge of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Alternate-function output levels |
| alt_oe | input | NPINS | Alternate-function output enables |
| alt_in | output | NPINS | Pad levels presented to the alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check four things on every cycle. Unmask and mask strobes change exactly the written bits. Status never loses a bit except through a status read. A status read returns the pre-clear value. Unimplemented read-data bits stay zero. The bench scenarios cover what needs a stimulus history: synchronizer latency, each detection mode telling wanted edges from ignored ones, an event that lands on the exact edge of a clearing read, level re-assertion after a clear, and output routing under bypass and direction settings.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  output logic [NPINS-1:0] alt_in,
  output logic             irq
);
  localparam logic [3:0] A_BYP  = 4'h0, A_DIR  = 4'h1, A_OE   = 4'h2, A_OUT  = 4'h3,
                         A_IN   = 4'h4, A_MSK  = 4'h5, A_UNM  = 4'h6, A_SETM = 4'h7,
                         A_STAT = 4'h8, A_TYPE = 4'h9, A_POL  = 4'hA, A_ANY  = 4'hB;
  localparam logic [NPINS-1:0] ALL = '1;

  logic [NPINS-1:0] byp, dir, oe, outv, mask, itype, pol, anye, stat;
  logic [NPINS-1:0] s1, s2, s3, ev;
  logic [31:0]      rmux;

  wire [3:0]       idx     = bus_addr[5:2];
  wire             wr_en   = bus_sel & bus_wr;
  wire             rd_en   = bus_sel & ~bus_wr;
  wire             rd_stat = rd_en & (idx == A_STAT);
  wire [NPINS-1:0] wd      = bus_wdata[NPINS-1:0];

  assign pin_out = (outv & ~byp) | (alt_out & byp);
  assign pin_oe  = (oe & ~dir & ~byp) | (alt_oe & byp);
  assign alt_in  = pin_in;
  assign irq     = |(stat & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp <= '0; dir <= ALL; oe <= '0; outv <= '0;
      mask <= ALL; itype <= '0; pol <= '0; anye <= '0;
    end else if (wr_en) begin
      case (idx)
        A_BYP:   byp   <= wd;
        A_DIR:   dir   <= wd;
        A_OE:    oe    <= wd;
        A_OUT:   outv  <= wd;
        A_UNM:   mask  <= mask & ~wd;
        A_SETM:  mask  <= mask | wd;
        A_TYPE:  itype <= wd;
        A_POL:   pol   <= wd;
        A_ANY:   anye  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      if (itype[i])
        ev[i] = pol[i] ? s2[i] : ~s2[i];
      else if (anye[i])
        ev[i] = s2[i] ^ s3[i];
      else
        ev[i] = pol[i] ? (s2[i] & ~s3[i]) : (~s2[i] & s3[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= rd_stat ? ev : (stat | ev);
  end

  always_comb begin
    case (idx)
      A_BYP:   rmux = 32'(byp);
      A_DIR:   rmux = 32'(dir);
      A_OE:    rmux = 32'(oe);
      A_OUT:   rmux = 32'(outv);
      A_IN:    rmux = 32'(s2);
      A_MSK:   rmux = 32'(mask);
      A_STAT:  rmux = 32'(stat);
      A_TYPE:  rmux = 32'(itype);
      A_POL:   rmux = 32'(pol);
      A_ANY:   rmux = 32'(anye);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rmux;
  end

  AST_UNMASK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == A_UNM) |=> (mask & $past(wd)) == '0);  // R5
  AST_MASK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == A_SETM) |=> (mask & $past(wd)) == $past(wd)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> (($past(stat) & ~stat) == '0));             // R9
  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> bus_rdata == 32'($past(stat)));               // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(bus_rdata) >> NPINS) == 64'd0);                       // R2
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 24;
  localparam logic [31:0] ALLN = 32'h00FF_FFFF;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0, alt_in;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  logic pend = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq));

  always @(posedge clk) pend <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read with no expected item: actual %h", bus_rdata);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back('{e, t});
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(1);
    // R1 reset values
    chk(32'(irq), 0, "R1 irq");
    chk(32'(pin_oe), 0, "R1 pin_oe");
    rd(6'h00, 0, "R1 bypass");
    rd(6'h04, ALLN, "R1 direction");
    rd(6'h08, 0, "R1 oe");
    rd(6'h0C, 0, "R1 outv");
    rd(6'h14, ALLN, "R1 mask");
    rd(6'h20, 0, "R1 status");
    rd(6'h24, 0, "R1 type");
    rd(6'h28, 0, "R1 polarity");
    rd(6'h2C, 0, "R1 anyedge");
    // R2 unused upper bits
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, ALLN, "R2 upper bits zero");
    // R3 direction / oe / value
    wr(6'h0C, 32'h0000_00A5);
    wr(6'h04, 32'h00FF_FF00);
    wr(6'h08, 32'h0000_000F);
    chk(32'(pin_out), 32'hA5, "R3 pin_out");
    chk(32'(pin_oe), 32'h0F, "R3 pin_oe output");
    wr(6'h04, ALLN);
    chk(32'(pin_oe), 0, "R3 oe ignored for inputs");
    // R4 bypass
    alt_out = 24'h123456; alt_oe = '1;
    wr(6'h00, 32'h0000_00F0);
    chk(32'(pin_out), 32'h55, "R4 bypass pin_out");
    chk(32'(pin_oe), 32'hF0, "R4 bypass pin_oe");
    pin_in = 24'h00ABCD;
    #1 chk(32'(alt_in), 32'h00ABCD, "R4 alt_in");
    pin_in = '0;
    wr(6'h00, 0);
    settle(4);
    rd(6'h20, 0, "R7 flush status");
    // R10 synchronizer latency
    pin_in = 24'h3;
    rd(6'h10, 0, "R10 same cycle");
    rd(6'h10, 0, "R10 one cycle later");
    rd(6'h10, 32'h3, "R10 after two flops");
    pin_in = '0;
    settle(4);
    rd(6'h20, 32'h3, "R7 default falling edge");
    // R6 level high, R9 masked latching, R8 re-set
    wr(6'h24, 32'h1);
    wr(6'h28, 32'h1);
    pin_in = 24'h1;
    settle(4);
    chk(32'(irq), 0, "R9 masked no irq");
    rd(6'h20, 32'h1, "R6 level high latched");
    rd(6'h20, 32'h1, "R8 active level re-sets");
    wr(6'h18, 32'h1);
    chk(32'(irq), 1, "R9 irq after unmask");
    pin_in = '0;
    settle(4);
    rd(6'h20, 32'h1, "R8 still latched");
    rd(6'h20, 0, "R8 cleared after level gone");
    chk(32'(irq), 0, "R9 irq drops");
    // R6 level low
    wr(6'h24, 32'h5);
    settle(2);
    rd(6'h20, 32'h4, "R6 level low");
    pin_in = 24'h4;
    settle(4);
    rd(6'h20, 32'h4, "R6 level low latched");
    rd(6'h20, 0, "R6 level low inactive");
    // R7 edge modes
    wr(6'h28, 32'h9);
    pin_in = 24'hC;
    settle(4);
    rd(6'h20, 32'h8, "R7 rising");
    rd(6'h20, 0, "R8 read cleared");
    pin_in = 24'h4;
    settle(4);
    rd(6'h20, 0, "R7 rising ignores fall");
    wr(6'h2C, 32'h10);
    pin_in = 24'h14;
    settle(4);
    rd(6'h20, 32'h10, "R7 any edge rise");
    pin_in = 24'h4;
    settle(4);
    rd(6'h20, 32'h10, "R7 any edge fall");
    pin_in = 24'h24;
    settle(4);
    rd(6'h20, 0, "R7 falling ignores rise");
    pin_in = 24'h4;
    settle(4);
    rd(6'h20, 32'h20, "R7 falling");
    // R8 event on the clearing edge
    pin_in = 24'h24;
    settle(4);
    rd(6'h20, 0, "R8 setup");
    pin_in = 24'h4;
    settle(2);
    rd(6'h20, 0, "R8 read on event edge");
    rd(6'h20, 32'h20, "R8 event kept");
    // R5 mask strobes
    wr(6'h18, 32'h30);
    rd(6'h14, 32'h00FF_FFCE, "R5 unmask strobe");
    wr(6'h1C, 32'h10);
    rd(6'h14, 32'h00FF_FFDE, "R5 mask strobe");
    wr(6'h14, 32'h0);
    rd(6'h14, 32'h00FF_FFDE, "R5 mask read only");
    rd(6'h18, 0, "R5 strobe reads zero");
    // R9 combined irq
    pin_in = 24'h24;
    settle(4);
    pin_in = 24'h4;
    settle(3);
    chk(32'(irq), 1, "R9 unmasked event");
    wr(6'h1C, 32'h20);
    chk(32'(irq), 0, "R9 masked again");
    wr(6'h18, 32'h20);
    chk(32'(irq), 1, "R11 unmask next edge");
    rd(6'h20, 32'h20, "R11 read data next cycle");
    chk(32'(irq), 0, "R9 irq cleared by read");
    settle(3);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule